// File: doc/BRIEF.md
# Dual-Port Burst RAM

This block is a synchronous RAM with two fully independent access ports. Each port has its own clock and can read or write any word of the shared array, including the word the other port is using in the same cycle. Every port samples its controls, address and write data on the rising edge of its clock. The address used for an access comes from a per-port burst counter. That counter can take in a new start address, step forward by one word, repeat the last address, or return to word zero, so a host can stream a burst after supplying only the first address.

Each word has two byte lanes of `LW` bits, and each lane has its own active-low select. A port is active only while its low-true enable is low and its high-true enable is high. Read data can be delivered flow-through, in the cycle after the capturing edge, or pipelined, one cycle later. A per-port input chooses between the two modes. The output drivers are represented by a data bus and a per-lane drive flag. An asynchronous release input forces both flags low at once.

Top module: `dpb_ram_top`

## Requirements
- R1: A write on an active port (`x_rnw`=0) stores only the lanes whose select bit in `x_lane_n` is 0. Bit 1 selects the upper lane, data bits [2*LW-1:LW]. Bit 0 selects the lower lane, data bits [LW-1:0]. Unselected lanes keep their stored contents.
- R2: A port is active only when `x_sel_n`=0 and `x_sel`=1. In every other combination the port neither writes nor starts a read.
- R3: On an edge where `x_clr_n`=1 and `x_ld_n`=0, the port takes `x_addr` as its access address for that cycle.
- R4: On an edge where `x_clr_n`=1, `x_ld_n`=1 and `x_step_n`=0, the port uses its previous address plus one. The count wraps from 2^AW-1 to 0.
- R5: On an edge where `x_clr_n`, `x_ld_n` and `x_step_n` are all 1, the port reuses its previous address and ignores `x_addr`.
- R6: On an edge where `x_clr_n`=0, the access address is 0, whatever `x_ld_n` and `x_step_n` are.
- R7: The counter actions of R3 to R6 take place whether or not the port is active, and whatever the lane selects are.
- R8: In flow-through mode (`x_pipe`=0), a read captured at edge N shows on `x_rdata` with `x_drv` set between edges N and N+1. Both ports may read at the same time.
- R9: In pipelined mode (`x_pipe`=1), a read captured at edge N shows between edges N+1 and N+2.
- R10: The enables are registered once in flow-through mode and twice in pipelined mode, so in pipelined mode the lanes stop driving only two edges after deselect. In both modes, the lane drive flags follow the lane selects sampled at the most recent edge.
- R11: While `x_quiet`=1, both of that port's drive flags are 0 at once, without waiting for a clock edge.
- R12: Each lane of `x_rdata` is zero whenever its drive flag is 0. After reset no lane drives.
- R13: If both ports write the same lane of the same word on the same edge, port A's data is stored. A read that coincides with the other port's write to the same word returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of counters and output stages |
| a_clk | input | 1 | Port A clock |
| a_sel_n | input | 1 | Port A enable, active low |
| a_sel | input | 1 | Port A enable, active high |
| a_rnw | input | 1 | Port A direction: 1 read, 0 write |
| a_lane_n | input | LANES | Port A lane selects, active low |
| a_ld_n | input | 1 | Port A take-address command, active low |
| a_step_n | input | 1 | Port A counter step command, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_pipe | input | 1 | Port A read mode: 1 pipelined, 0 flow-through |
| a_quiet | input | 1 | Port A asynchronous drive release |
| a_addr | input | AW | Port A external address |
| a_wdata | input | LW*LANES | Port A write data |
| a_rdata | output | LW*LANES | Port A read data, zero on undriven lanes |
| a_drv | output | LANES | Port A per-lane drive flags |
| b_clk | input | 1 | Port B clock |
| b_sel_n | input | 1 | Port B enable, active low |
| b_sel | input | 1 | Port B enable, active high |
| b_rnw | input | 1 | Port B direction: 1 read, 0 write |
| b_lane_n | input | LANES | Port B lane selects, active low |
| b_ld_n | input | 1 | Port B take-address command, active low |
| b_step_n | input | 1 | Port B counter step command, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_pipe | input | 1 | Port B read mode: 1 pipelined, 0 flow-through |
| b_quiet | input | 1 | Port B asynchronous drive release |
| b_addr | input | AW | Port B external address |
| b_wdata | input | LW*LANES | Port B write data |
| b_rdata | output | LW*LANES | Port B read data, zero on undriven lanes |
| b_drv | output | LANES | Port B per-lane drive flags |

## Verification
The bench builds the block with AW=4, LW=9 and LANES=2. This gives a 16-word array with two 9-bit lanes. With so few words, one sweep fills the whole array, and a short burst carries the counter across its wrap from 15 to 0. Both ports share one clock edge in the bench, so same-word collisions and read-during-write cases occur exactly on coinciding edges. The bench reads port A in flow-through mode and switches port B between the two read modes, which covers the one-stage and two-stage deselect timing.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

    // Counter operation chosen on each port clock edge
    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_STEP  = 2'd1,
        CTR_LOAD  = 2'd2,
        CTR_CLEAR = 2'd3
    } ctr_op_e;

    // Clear outranks load, load outranks step
    function automatic ctr_op_e ctr_pick(input logic clr_n, input logic ld_n,
                                         input logic step_n);
        if (!clr_n)       return CTR_CLEAR;
        else if (!ld_n)   return CTR_LOAD;
        else if (!step_n) return CTR_STEP;
        else              return CTR_HOLD;
    endfunction

endpackage

// File: rtl/dpb_addr_ctr.sv
module dpb_addr_ctr
    import dpb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          ld_n,
    input  logic          step_n,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr_nxt,
    output logic [AW-1:0] addr_q
);

    ctr_op_e op;

    // Access address for this edge; it is also the next counter value
    always_comb begin
        op = ctr_pick(clr_n, ld_n, step_n);
        unique case (op)
            CTR_CLEAR: addr_nxt = '0;
            CTR_LOAD:  addr_nxt = ext_addr;
            CTR_STEP:  addr_nxt = addr_q + 1'b1;
            CTR_HOLD:  addr_nxt = addr_q;
        endcase
    end

    // Counter register: enables and lane selects play no part here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_nxt;
    end

endmodule

// File: rtl/dpb_out_stage.sv
module dpb_out_stage #(
    parameter int LW    = 9,
    parameter int LANES = 2,
    localparam int DW   = LW * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe,
    input  logic             quiet,
    input  logic             rd_fire,
    input  logic [LANES-1:0] lane_on,
    input  logic [DW-1:0]    rq,
    output logic [DW-1:0]    rdata,
    output logic [LANES-1:0] drv
);

    logic             rd1_q, rd2_q;
    logic [LANES-1:0] lane_q;
    logic [DW-1:0]    dat2_q;
    logic             live;
    logic [DW-1:0]    src;

    // Read-valid passes one or two stages; lane selects only one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd1_q  <= 1'b0;
            rd2_q  <= 1'b0;
            lane_q <= '0;
            dat2_q <= '0;
        end else begin
            rd1_q  <= rd_fire;
            rd2_q  <= rd1_q;
            lane_q <= lane_on;
            dat2_q <= rq;
        end
    end

    always_comb begin
        live = pipe ? rd2_q : rd1_q;
        src  = pipe ? dat2_q : rq;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign drv[l]                 = live & lane_q[l] & ~quiet;
        assign rdata[l*LW +: LW]      = drv[l] ? src[l*LW +: LW] : '0;
    end

endmodule

// File: rtl/dpb_dual_array.sv
module dpb_dual_array #(
    parameter int AW    = 10,
    parameter int LW    = 9,
    parameter int LANES = 2,
    localparam int DW    = LW * LANES,
    localparam int DEPTH = 1 << AW
) (
    input  logic             rst_n,
    input  logic             a_clk,
    input  logic [AW-1:0]    a_addr,
    input  logic [LANES-1:0] a_we,
    input  logic             a_re,
    input  logic [DW-1:0]    a_wd,
    output logic [DW-1:0]    a_rq,
    input  logic             b_clk,
    input  logic [AW-1:0]    b_addr,
    input  logic [LANES-1:0] b_we,
    input  logic             b_re,
    input  logic [DW-1:0]    b_wd,
    output logic [DW-1:0]    b_rq
);

    // One bank per writer; per-lane tags tell which bank is newest
    logic [DW-1:0]    bank_a [DEPTH];
    logic [DW-1:0]    bank_b [DEPTH];
    logic [LANES-1:0] tag_a  [DEPTH];
    logic [LANES-1:0] tag_b  [DEPTH];
    logic [LANES-1:0] b_block;

    // Equal tags: port A wrote last; unequal: port B wrote last
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] wa,
                                            input logic [DW-1:0] wb,
                                            input logic [LANES-1:0] ta,
                                            input logic [LANES-1:0] tb);
        logic [DW-1:0] w;
        for (int l = 0; l < LANES; l++)
            w[l*LW +: LW] = (ta[l] == tb[l]) ? wa[l*LW +: LW] : wb[l*LW +: LW];
        return w;
    endfunction

    // Port A wins a lane it writes at the same word on this edge
    always_comb begin
        for (int l = 0; l < LANES; l++)
            b_block[l] = a_we[l] && (a_addr == b_addr);
    end

    always_ff @(posedge a_clk) begin
        for (int l = 0; l < LANES; l++)
            if (a_we[l]) bank_a[a_addr][l*LW +: LW] <= a_wd[l*LW +: LW];
    end

    always_ff @(posedge a_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tag_a[i] <= '0;
            a_rq <= '0;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (a_we[l]) tag_a[a_addr][l] <= tag_b[a_addr][l];
            if (a_re)
                a_rq <= merge(bank_a[a_addr], bank_b[a_addr], tag_a[a_addr], tag_b[a_addr]);
        end
    end

    always_ff @(posedge b_clk) begin
        for (int l = 0; l < LANES; l++)
            if (b_we[l] && !b_block[l]) bank_b[b_addr][l*LW +: LW] <= b_wd[l*LW +: LW];
    end

    always_ff @(posedge b_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tag_b[i] <= '0;
            b_rq <= '0;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (b_we[l] && !b_block[l]) tag_b[b_addr][l] <= ~tag_a[b_addr][l];
            if (b_re)
                b_rq <= merge(bank_a[b_addr], bank_b[b_addr], tag_a[b_addr], tag_b[b_addr]);
        end
    end

endmodule

// File: rtl/dpb_ram_top.sv
module dpb_ram_top #(
    parameter int AW    = 10,
    parameter int LW    = 9,
    parameter int LANES = 2,
    localparam int DW   = LW * LANES
) (
    input  logic             rst_n,
    input  logic             a_clk,
    input  logic             a_sel_n,
    input  logic             a_sel,
    input  logic             a_rnw,
    input  logic [LANES-1:0] a_lane_n,
    input  logic             a_ld_n,
    input  logic             a_step_n,
    input  logic             a_clr_n,
    input  logic             a_pipe,
    input  logic             a_quiet,
    input  logic [AW-1:0]    a_addr,
    input  logic [DW-1:0]    a_wdata,
    output logic [DW-1:0]    a_rdata,
    output logic [LANES-1:0] a_drv,
    input  logic             b_clk,
    input  logic             b_sel_n,
    input  logic             b_sel,
    input  logic             b_rnw,
    input  logic [LANES-1:0] b_lane_n,
    input  logic             b_ld_n,
    input  logic             b_step_n,
    input  logic             b_clr_n,
    input  logic             b_pipe,
    input  logic             b_quiet,
    input  logic [AW-1:0]    b_addr,
    input  logic [DW-1:0]    b_wdata,
    output logic [DW-1:0]    b_rdata,
    output logic [LANES-1:0] b_drv
);

    logic             a_ok, b_ok;
    logic [AW-1:0]    a_use, b_use;
    logic [AW-1:0]    a_cur, b_cur;
    logic [LANES-1:0] a_we, b_we;
    logic             a_re, b_re;
    logic [DW-1:0]    a_rq, b_rq;

    // Port decode: both enables must agree
    always_comb begin
        a_ok = ~a_sel_n & a_sel;
        b_ok = ~b_sel_n & b_sel;
        a_we = {LANES{a_ok & ~a_rnw}} & ~a_lane_n;
        b_we = {LANES{b_ok & ~b_rnw}} & ~b_lane_n;
        a_re = a_ok & a_rnw;
        b_re = b_ok & b_rnw;
    end

    dpb_addr_ctr #(.AW(AW)) u_ctr_a (
        .clk(a_clk), .rst_n(rst_n), .clr_n(a_clr_n), .ld_n(a_ld_n),
        .step_n(a_step_n), .ext_addr(a_addr), .addr_nxt(a_use), .addr_q(a_cur)
    );

    dpb_addr_ctr #(.AW(AW)) u_ctr_b (
        .clk(b_clk), .rst_n(rst_n), .clr_n(b_clr_n), .ld_n(b_ld_n),
        .step_n(b_step_n), .ext_addr(b_addr), .addr_nxt(b_use), .addr_q(b_cur)
    );

    dpb_dual_array #(.AW(AW), .LW(LW), .LANES(LANES)) u_array (
        .rst_n(rst_n),
        .a_clk(a_clk), .a_addr(a_use), .a_we(a_we), .a_re(a_re), .a_wd(a_wdata), .a_rq(a_rq),
        .b_clk(b_clk), .b_addr(b_use), .b_we(b_we), .b_re(b_re), .b_wd(b_wdata), .b_rq(b_rq)
    );

    dpb_out_stage #(.LW(LW), .LANES(LANES)) u_out_a (
        .clk(a_clk), .rst_n(rst_n), .pipe(a_pipe), .quiet(a_quiet), .rd_fire(a_re),
        .lane_on(~a_lane_n), .rq(a_rq), .rdata(a_rdata), .drv(a_drv)
    );

    dpb_out_stage #(.LW(LW), .LANES(LANES)) u_out_b (
        .clk(b_clk), .rst_n(rst_n), .pipe(b_pipe), .quiet(b_quiet), .rd_fire(b_re),
        .lane_on(~b_lane_n), .rq(b_rq), .rdata(b_rdata), .drv(b_drv)
    );

endmodule

// File: rtl/dpb_ram_chk.sv
module dpb_ram_chk #(
    parameter int AW    = 10,
    parameter int LANES = 2
) (
    input logic             rst_n,
    input logic             a_clk,
    input logic             a_sel_n,
    input logic             a_sel,
    input logic             a_pipe,
    input logic             a_quiet,
    input logic             a_clr_n,
    input logic             a_ld_n,
    input logic             a_step_n,
    input logic [AW-1:0]    a_addr,
    input logic [AW-1:0]    a_cur,
    input logic [LANES-1:0] a_drv,
    input logic             b_clk,
    input logic             b_quiet,
    input logic [LANES-1:0] b_drv
);

    logic a_on;
    assign a_on = ~a_sel_n & a_sel;

    // R6
    ctr_clear_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        !a_clr_n |=> (a_cur == '0));

    // R3
    ctr_load_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_clr_n && !a_ld_n) |=> (a_cur == $past(a_addr)));

    // R4
    ctr_step_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_clr_n && a_ld_n && !a_step_n) |=> (a_cur == AW'($past(a_cur) + 1'b1)));

    // R5
    ctr_hold_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_clr_n && a_ld_n && a_step_n) |=> $stable(a_cur));

    // R11
    quiet_a_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_quiet |-> (a_drv == '0));

    // R11
    quiet_b_chk: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_quiet |-> (b_drv == '0));

    // R10
    flow_desel_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!a_pipe && !a_on) |=> (a_pipe || a_drv == '0));

    // R10
    pipe_desel_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_pipe && $past(a_pipe) && !a_on && !$past(a_on)) |=> (!a_pipe || a_drv == '0));

endmodule

bind dpb_ram_top dpb_ram_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_sel_n(a_sel_n), .a_sel(a_sel), .a_pipe(a_pipe), .a_quiet(a_quiet),
    .a_clr_n(a_clr_n), .a_ld_n(a_ld_n), .a_step_n(a_step_n), .a_addr(a_addr),
    .a_cur(a_cur), .a_drv(a_drv),
    .b_clk(b_clk), .b_quiet(b_quiet), .b_drv(b_drv)
);

// File: tb/dpb_ram_top_test.sv
module dpb_ram_top_test;

    localparam int PERIOD = 10;
    localparam int AW     = 4;
    localparam int LW     = 9;
    localparam int LANES  = 2;
    localparam int DW     = LW * LANES;
    localparam int DEPTH  = 1 << AW;

    typedef struct packed {
        logic          sel_n;
        logic          sel;
        logic          rnw;
        logic          ld_n;
        logic          step_n;
        logic          clr_n;
        logic          pipe;
        logic          quiet;
        logic [1:0]    lane_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
    } pin_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    pin_t pa, pb;
    logic [DW-1:0]    a_rdata, b_rdata;
    logic [LANES-1:0] a_drv, b_drv;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    logic [DW-1:0] mem [DEPTH];
    int            cur [2];
    logic          rd1 [2];
    logic          rd2 [2];
    logic [DW-1:0] w1  [2];
    logic [DW-1:0] w2  [2];
    logic [1:0]    lq  [2];

    always #(PERIOD/2) clk = ~clk;

    dpb_ram_top #(.AW(AW), .LW(LW), .LANES(LANES)) uut (
        .rst_n(rst_n),
        .a_clk(clk), .a_sel_n(pa.sel_n), .a_sel(pa.sel), .a_rnw(pa.rnw), .a_lane_n(pa.lane_n),
        .a_ld_n(pa.ld_n), .a_step_n(pa.step_n), .a_clr_n(pa.clr_n), .a_pipe(pa.pipe),
        .a_quiet(pa.quiet), .a_addr(pa.addr), .a_wdata(pa.wd), .a_rdata(a_rdata), .a_drv(a_drv),
        .b_clk(clk), .b_sel_n(pb.sel_n), .b_sel(pb.sel), .b_rnw(pb.rnw), .b_lane_n(pb.lane_n),
        .b_ld_n(pb.ld_n), .b_step_n(pb.step_n), .b_clr_n(pb.clr_n), .b_pipe(pb.pipe),
        .b_quiet(pb.quiet), .b_addr(pb.addr), .b_wdata(pb.wd), .b_rdata(b_rdata), .b_drv(b_drv)
    );

    function automatic pin_t idle(input logic pipe);
        pin_t p;
        p = '0;
        p.sel_n = 1'b1; p.sel = 1'b1; p.rnw = 1'b1;
        p.ld_n = 1'b1; p.step_n = 1'b1; p.clr_n = 1'b1;
        p.pipe = pipe;
        return p;
    endfunction

    function automatic pin_t rd(input logic pipe, input logic load, input int a);
        pin_t p;
        p = idle(pipe);
        p.sel_n = 1'b0;
        p.ld_n = !load; p.step_n = load; p.addr = AW'(a);
        return p;
    endfunction

    function automatic pin_t wr(input logic load, input int a, input logic [DW-1:0] d,
                                input logic [1:0] lane_n);
        pin_t p;
        p = idle(1'b0);
        p.sel_n = 1'b0; p.rnw = 1'b0;
        p.ld_n = !load; p.step_n = load; p.addr = AW'(a);
        p.wd = d; p.lane_n = lane_n;
        return p;
    endfunction

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 11213 + 777);
    endfunction

    // Reference effect of one shared clock edge
    task automatic model_edge();
        pin_t          pp [2];
        int            acc [2];
        logic          ok [2];
        logic [DW-1:0] rw [2];
        pp[0] = pa; pp[1] = pb;
        for (int p = 0; p < 2; p++) begin
            ok[p] = !pp[p].sel_n && pp[p].sel;
            if (!pp[p].clr_n)       acc[p] = 0;
            else if (!pp[p].ld_n)   acc[p] = int'(pp[p].addr);
            else if (!pp[p].step_n) acc[p] = (cur[p] + 1) % DEPTH;
            else                    acc[p] = cur[p];
            cur[p] = acc[p];
            rw[p]  = mem[acc[p]];
        end
        // port B first so that port A overwrites on a collision
        for (int p = 1; p >= 0; p--)
            if (ok[p] && !pp[p].rnw)
                for (int l = 0; l < LANES; l++)
                    if (!pp[p].lane_n[l]) mem[acc[p]][l*LW +: LW] = pp[p].wd[l*LW +: LW];
        for (int p = 0; p < 2; p++) begin
            w2[p]  = w1[p];
            rd2[p] = rd1[p];
            rd1[p] = ok[p] && pp[p].rnw;
            if (rd1[p]) w1[p] = rw[p];
            lq[p]  = ~pp[p].lane_n;
        end
    endtask

    task automatic check_port(input int p, input string tag);
        pin_t          pp;
        logic          live;
        logic [1:0]    ed;
        logic [DW-1:0] src, edd, ad;
        logic [1:0]    adr;
        pp   = (p == 0) ? pa : pb;
        live = pp.pipe ? rd2[p] : rd1[p];
        src  = pp.pipe ? w2[p] : w1[p];
        ed   = live ? (lq[p] & ~{2{pp.quiet}}) : 2'b00;
        edd  = '0;
        for (int l = 0; l < LANES; l++)
            if (ed[l]) edd[l*LW +: LW] = src[l*LW +: LW];
        ad  = (p == 0) ? a_rdata : b_rdata;
        adr = (p == 0) ? a_drv : b_drv;
        checks++;
        if (ad !== edd || adr !== ed) begin
            fails++;
            $display("FAIL %s port %0d: got drv=%b data=%h, expected drv=%b data=%h",
                     tag, p, adr, ad, ed, edd);
        end
    endtask

    task automatic tick(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check_port(0, tag);
        check_port(1, tag);
    endtask

    initial begin
        #(PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        pa = idle(1'b0);
        pb = idle(1'b0);
        for (int i = 0; i < DEPTH; i++) mem[i] = 'x;
        for (int p = 0; p < 2; p++) begin
            cur[p] = 0; rd1[p] = 0; rd2[p] = 0; w1[p] = '0; w2[p] = '0; lq[p] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_port(0, "R12 reset");
        check_port(1, "R12 reset");

        // R1 fill every word from port A with a load then steps
        for (int i = 0; i < DEPTH; i++) begin
            pa = wr(i == 0, 0, pat(i), 2'b00);
            tick("R1 fill");
        end
        pa = idle(1'b0);

        // R4 and R8: burst read on B across the wrap
        pb = rd(1'b0, 1'b1, 12);
        tick("R3 load");
        for (int i = 0; i < 7; i++) begin
            pb = rd(1'b0, 1'b0, 0);
            tick("R4 wrap");
        end

        // R1 lane-limited writes, R12 partial lane drive
        pb = idle(1'b0);
        pa = wr(1'b1, 3, 18'h3FFFF, 2'b01);
        tick("R1 upper");
        pa = wr(1'b1, 4, 18'h00000, 2'b10);
        tick("R1 lower");
        pa = idle(1'b0);
        pb = rd(1'b0, 1'b1, 3);
        tick("R1 readback");
        pb = rd(1'b0, 1'b1, 4);
        tick("R1 readback");
        pb = rd(1'b0, 1'b1, 3);
        pb.lane_n = 2'b10;
        tick("R12 lane off");

        // R2 deselected writes have no effect
        pb = idle(1'b0);
        pa = wr(1'b1, 5, 18'h15555, 2'b00);
        pa.sel_n = 1'b1;
        tick("R2 desel write");
        pa = wr(1'b1, 6, 18'h2AAAA, 2'b00);
        pa.sel = 1'b0;
        tick("R2 desel write");
        pa = idle(1'b0);
        pb = rd(1'b0, 1'b1, 5);
        tick("R2 readback");
        pb = rd(1'b0, 1'b1, 6);
        tick("R2 readback");
        pb = rd(1'b0, 1'b1, 7);
        pb.sel = 1'b0;
        tick("R2 desel read");

        // R5 hold ignores the external address
        pb = rd(1'b0, 1'b1, 9);
        tick("R3 load");
        pb = rd(1'b0, 1'b0, 2);
        pb.step_n = 1'b1;
        tick("R5 hold");
        tick("R5 hold");

        // R6 clear overrides load and step
        pb = rd(1'b0, 1'b1, 9);
        pb.clr_n = 1'b0;
        tick("R6 clear");
        pb = rd(1'b0, 1'b0, 9);
        pb.clr_n = 1'b0;
        tick("R6 clear");

        // R7 counter loads while deselected, then steps
        pb = rd(1'b0, 1'b1, 7);
        pb.sel_n = 1'b1;
        pb.lane_n = 2'b11;
        tick("R7 desel load");
        pb = rd(1'b0, 1'b0, 0);
        tick("R7 step after");

        // R9 and R10 pipelined reads and deselect timing on B
        pb = idle(1'b1);
        tick("R9 idle");
        pb = rd(1'b1, 1'b1, 10);
        tick("R9 first");
        pb = rd(1'b1, 1'b0, 0);
        tick("R9 second");
        pb = rd(1'b1, 1'b0, 0);
        pb.sel_n = 1'b1;
        pb.lane_n = 2'b01;
        tick("R10 pipe desel one");
        tick("R10 pipe desel two");
        tick("R10 pipe desel three");

        // R10 flow-through deselect on A
        pa = rd(1'b0, 1'b1, 1);
        tick("R8 read");
        pa = idle(1'b0);
        tick("R10 flow desel");

        // R11 asynchronous release during bursts
        pb = rd(1'b1, 1'b1, 0);
        pa = rd(1'b0, 1'b1, 8);
        tick("R11 burst");
        pb = rd(1'b1, 1'b0, 0);
        pa = rd(1'b0, 1'b0, 0);
        pb.quiet = 1'b1;
        pa.quiet = 1'b1;
        tick("R11 quiet");
        pb = rd(1'b1, 1'b0, 0);
        pa = rd(1'b0, 1'b0, 0);
        tick("R11 resume");
        pb = idle(1'b0);
        pa = idle(1'b0);
        tick("R11 idle");
        tick("R11 idle");

        // R13 collisions
        pa = wr(1'b1, 11, 18'h12345, 2'b00);
        pb = wr(1'b1, 11, 18'h2BCDE, 2'b00);
        tick("R13 same word");
        pa = wr(1'b1, 13, 18'h3F0F0, 2'b01);
        pb = wr(1'b1, 13, 18'h00F0F, 2'b10);
        tick("R13 split lanes");
        pa = wr(1'b1, 2, 18'h11111, 2'b00);
        pb = rd(1'b0, 1'b1, 2);
        tick("R13 read old");
        pa = rd(1'b0, 1'b1, 14);
        pb = wr(1'b1, 14, 18'h22222, 2'b00);
        tick("R13 read old");
        pa = rd(1'b0, 1'b1, 14);
        pb = rd(1'b0, 1'b1, 11);
        tick("R13 readback");
        pa = rd(1'b0, 1'b1, 2);
        pb = rd(1'b0, 1'b1, 13);
        tick("R13 readback");

        // R8 independent simultaneous reads
        pa = rd(1'b0, 1'b1, 15);
        pb = rd(1'b0, 1'b1, 0);
        tick("R8 both ports");
        pa = idle(1'b0);
        pb = idle(1'b0);
        tick("R12 final idle");

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule